// File: doc/BRIEF.md
# Debug Command Execution Engine

The engine takes one debug request frame that has already been received and checked. The frame is a function code, a length byte and a flat payload vector. The engine carries out the request as a sequence of single-byte accesses on a simple memory bus. The bus has 16-bit addresses, 8-bit data, separate read and write strobes and a ready input.

It then streams a reply frame out on a valid/ready byte interface. The reply is the function byte, a length byte, the data bytes and a closing checksum byte. When the final reply byte has been taken, the engine pulses `done` for one cycle, which tells the receiver that the next frame may be presented.

Six requests are handled:

- memory read;
- memory write, verified by read-back;
- multi-location byte set, which returns the old data and aborts on a failed verify;
- port input;
- port output, with no verify;
- a descriptor query.

Any other code gets an error reply. Every address field arrives low byte first. In memory requests, a page byte that the engine ignores comes before the address.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, `tx_valid`, `bus_rd`, `bus_wr` and `done` are all low, and the engine waits for `frm_start`.
- R2: A function code outside {0xFF, 0xFE, 0xFD, 0xF9, 0xF8, 0xF7} gives a reply of function byte 0xF0, length 1 and status byte 0x01. It makes no bus access.
- R3: Code 0xFE (memory read) uses payload bytes 0 = page (ignored), 1 = address low, 2 = address high and 3 = count N. The reply has length N, followed by N bytes read from consecutive addresses starting at {high, low}. A count of 0 makes no access.
- R4: Code 0xFD (memory write) uses payload bytes 0 = page, 1 = address low and 2 = address high, followed by length−3 data bytes. The engine writes all of them to consecutive addresses, then reads them back in order. The status is 0 if every byte matches, and 1 at the first mismatch, with no further reads. A length of 3 or less makes no access and returns status 0.
- R5: Code 0xF9 (set bytes) processes length/4 groups of page, address low, address high and data, one group at a time. For each group the engine reads the old byte, writes the new one and reads it back. When the verify succeeds, the old byte is appended to the reply. A failed verify ends the request, and later groups are not touched. The reply length is the number of groups completed.
- R6: Code 0xF7 (port output) uses payload bytes 0 = address low, 1 = address high and 2 = data. It makes exactly one write and no read, and returns status 0.
- R7: Code 0xF8 (port input) uses payload bytes 0 = address low and 1 = address high. It makes one read and returns the byte read as the status.
- R8: Every reply has function, length, data and checksum, and is exactly length+3 bytes long. A status reply has length 1. The function byte echoes the request, except for the error reply. The checksum is the two's-complement negation of the 8-bit sum of the function, length and data bytes.
- R9: Code 0xFF (descriptor query) returns length `DESC_LEN` followed by the parameter `DESC`, taken byte 0 (least significant) first.
- R10: A bus strobe and its address and write data stay unchanged until the cycle in which `bus_ready` is seen. Read and write are never asserted together, and no strobe is active while `tx_valid` is high.
- R11: `tx_valid` and `tx_data` stay unchanged until `tx_ready` is seen.
- R12: `done` is a single-cycle pulse in the cycle after the last reply byte is accepted, and it occurs once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | Pulse while idle: frame fields are valid |
| frm_func | input | 8 | Request function code |
| frm_len | input | 8 | Request payload length |
| frm_data | input | 8*MAX_LEN | Payload, byte i at bits 8i+7:8i, held until done |
| done | output | 1 | One-cycle pulse after the reply is sent |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 8 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes in this cycle |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The start of a request shows up on the bus, or at the first reply byte, one cycle after the `frm_start` edge. Each later bus access or reply byte follows one cycle after the edge that completed the previous one. `done` rises one cycle after the edge that accepts the final byte. The bench drives `bus_ready` and `tx_ready` at the falling edge, after counting its own wait states. It records every handshake, every memory write and the `done` pulse at that same falling edge, so each captured value is the one that the next rising edge consumes. Results are compared only after the counted `done`, and any state a request may have changed is read back through a later read request.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int MAX_LEN = 128,
  parameter int DESC_LEN = 6,
  parameter logic [8*DESC_LEN-1:0] DESC = 48'h0000_0000_8005
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_start,
  input  logic [7:0]           frm_func,
  input  logic [7:0]           frm_len,
  input  logic [8*MAX_LEN-1:0] frm_data,
  output logic                 done,
  output logic [15:0]          bus_addr,
  output logic [7:0]           bus_wdata,
  output logic                 bus_rd,
  output logic                 bus_wr,
  input  logic [7:0]           bus_rdata,
  input  logic                 bus_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready
);
  localparam int SBMAX = MAX_LEN / 4;
  localparam int SBW = (SBMAX > 1) ? $clog2(SBMAX) : 1;

  typedef enum logic [3:0] {IDLE, WRM, VFM, SRD, SWR, SVF, PIN, POUT, TXRD, TX, FIN} st_t;
  typedef enum logic [1:0] {SRC_STAT, SRC_DESC, SRC_BUF, SRC_MEM} src_t;

  st_t        st;
  src_t       src;
  logic [7:0] rfunc, rlen, sum, cur, status_q, k, last, cnt, old_q;
  logic [8:0] ti;
  logic [15:0] base;
  logic [7:0] sbuf [SBMAX];

  function automatic logic [7:0] pb(input logic [9:0] i);
    return 8'(frm_data >> {i, 3'b000});
  endfunction

  logic [8:0] ni, tlast;
  logic [7:0] nsum, j, nbyte, kp1;
  logic       need_rd, sv_ok, sb_we;

  assign ni      = ti + 9'd1;
  assign tlast   = {1'b0, rlen} + 9'd2;
  assign nsum    = sum + cur;
  assign j       = 8'(ni - 9'd2);
  assign kp1     = k + 8'd1;
  assign need_rd = (src == SRC_MEM) && (ni >= 9'd2) && (ni < tlast);
  assign sv_ok   = (bus_rdata == pb({k, 2'b11}));
  assign sb_we   = (st == SVF) && bus_ready && sv_ok;

  always_comb begin
    if (ni == 9'd1) nbyte = rlen;
    else if (ni == tlast) nbyte = 8'd0 - nsum;
    else begin
      case (src)
        SRC_STAT: nbyte = status_q;
        SRC_DESC: nbyte = 8'(DESC >> {j, 3'b000});
        SRC_BUF:  nbyte = sbuf[j[SBW-1:0]];
        default:  nbyte = 8'd0;
      endcase
    end
  end

  assign tx_valid = (st == TX);
  assign tx_data  = cur;
  assign done     = (st == FIN);

  always_ff @(posedge clk) begin
    if (sb_we) sbuf[cnt[SBW-1:0]] <= old_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      src <= SRC_STAT;
      rfunc <= '0;
      rlen <= '0;
      sum <= '0;
      cur <= '0;
      status_q <= '0;
      k <= '0;
      last <= '0;
      cnt <= '0;
      old_q <= '0;
      ti <= '0;
      base <= '0;
      bus_addr <= '0;
      bus_wdata <= '0;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
    end else begin
      case (st)
        IDLE: if (frm_start) begin
          rfunc <= frm_func;
          cur <= frm_func;
          ti <= '0;
          sum <= '0;
          k <= '0;
          cnt <= '0;
          case (frm_func)
            8'hFF: begin
              rlen <= DESC_LEN[7:0];
              src <= SRC_DESC;
              st <= TX;
            end
            8'hFE: begin
              rlen <= pb(10'd3);
              base <= {pb(10'd2), pb(10'd1)};
              src <= SRC_MEM;
              st <= TX;
            end
            8'hFD: begin
              if (frm_len > 8'd3) begin
                base <= {pb(10'd2), pb(10'd1)};
                bus_addr <= {pb(10'd2), pb(10'd1)};
                bus_wdata <= pb(10'd3);
                bus_wr <= 1'b1;
                last <= frm_len - 8'd4;
                st <= WRM;
              end else begin
                status_q <= 8'd0;
                rlen <= 8'd1;
                src <= SRC_STAT;
                st <= TX;
              end
            end
            8'hF9: begin
              if (frm_len[7:2] != 6'd0) begin
                last <= {2'b00, frm_len[7:2]} - 8'd1;
                bus_addr <= {pb(10'd2), pb(10'd1)};
                bus_rd <= 1'b1;
                st <= SRD;
              end else begin
                rlen <= 8'd0;
                src <= SRC_BUF;
                st <= TX;
              end
            end
            8'hF8: begin
              bus_addr <= {pb(10'd1), pb(10'd0)};
              bus_rd <= 1'b1;
              st <= PIN;
            end
            8'hF7: begin
              bus_addr <= {pb(10'd1), pb(10'd0)};
              bus_wdata <= pb(10'd2);
              bus_wr <= 1'b1;
              st <= POUT;
            end
            default: begin
              rfunc <= 8'hF0;
              cur <= 8'hF0;
              status_q <= 8'd1;
              rlen <= 8'd1;
              src <= SRC_STAT;
              st <= TX;
            end
          endcase
        end
        WRM: if (bus_ready) begin
          if (k == last) begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b1;
            bus_addr <= base;
            k <= '0;
            st <= VFM;
          end else begin
            k <= kp1;
            bus_addr <= base + 16'(kp1);
            bus_wdata <= pb({2'b00, k} + 10'd4);
          end
        end
        VFM: if (bus_ready) begin
          if (bus_rdata != pb({2'b00, k} + 10'd3)) begin
            bus_rd <= 1'b0;
            status_q <= 8'd1;
            rlen <= 8'd1;
            src <= SRC_STAT;
            st <= TX;
          end else if (k == last) begin
            bus_rd <= 1'b0;
            status_q <= 8'd0;
            rlen <= 8'd1;
            src <= SRC_STAT;
            st <= TX;
          end else begin
            k <= kp1;
            bus_addr <= base + 16'(kp1);
          end
        end
        SRD: if (bus_ready) begin
          old_q <= bus_rdata;
          bus_rd <= 1'b0;
          bus_wr <= 1'b1;
          bus_wdata <= pb({k, 2'b11});
          st <= SWR;
        end
        SWR: if (bus_ready) begin
          bus_wr <= 1'b0;
          bus_rd <= 1'b1;
          st <= SVF;
        end
        SVF: if (bus_ready) begin
          if (sv_ok && (k != last)) begin
            cnt <= cnt + 8'd1;
            k <= kp1;
            bus_addr <= {pb({kp1, 2'b10}), pb({kp1, 2'b01})};
            st <= SRD;
          end else begin
            bus_rd <= 1'b0;
            rlen <= sv_ok ? cnt + 8'd1 : cnt;
            cnt <= sv_ok ? cnt + 8'd1 : cnt;
            src <= SRC_BUF;
            st <= TX;
          end
        end
        PIN: if (bus_ready) begin
          bus_rd <= 1'b0;
          status_q <= bus_rdata;
          rlen <= 8'd1;
          src <= SRC_STAT;
          st <= TX;
        end
        POUT: if (bus_ready) begin
          bus_wr <= 1'b0;
          status_q <= 8'd0;
          rlen <= 8'd1;
          src <= SRC_STAT;
          st <= TX;
        end
        TX: if (tx_ready) begin
          if (ti == tlast) begin
            st <= FIN;
          end else begin
            sum <= nsum;
            ti <= ni;
            if (need_rd) begin
              bus_rd <= 1'b1;
              bus_addr <= base + 16'(j);
              st <= TXRD;
            end else begin
              cur <= nbyte;
            end
          end
        end
        TXRD: if (bus_ready) begin
          bus_rd <= 1'b0;
          cur <= bus_rdata;
          st <= TX;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module dbg_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_ready,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        done
);
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r10_no_bus_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && (bus_rd || bus_wr)));
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tx_valid && tx_ready));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .done(done)
);

// File: tb/test_dbg_cmd_engine.sv
module test_dbg_cmd_engine;
  localparam int CLK_NS = 10;
  localparam int MAXL = 16;
  localparam int DLEN = 5;
  localparam logic [8*DLEN-1:0] DVAL = 40'h41_0A_10_00_05;

  logic clk = 1'b0, rst_n = 1'b0, frm_start = 1'b0;
  logic [7:0] frm_func = '0, frm_len = '0;
  logic [8*MAXL-1:0] frm_data = '0;
  logic done, bus_rd, bus_wr, tx_valid;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, tx_data;
  logic bus_ready = 1'b0, tx_ready = 1'b0;

  dbg_cmd_engine #(.MAX_LEN(MAXL), .DESC_LEN(DLEN), .DESC(DVAL)) i_dbg_cmd_engine (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_func(frm_func), .frm_len(frm_len),
    .frm_data(frm_data), .done(done), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] mem [256];
  logic [7:0] rx [1024];
  logic [7:0] ex [260];
  int elen, total = 0, bad = 0;
  int nrd = 0, nwr = 0, nrx = 0, ndone = 0, done_nrx = 0, tviol = 0, bviol = 0;
  int wc = 0, txc = 0, delay = 0;
  bit stall = 0, ptv = 0, pbs = 0;
  logic [7:0] ptd;
  logic [15:0] pba, last_waddr = '0, last_raddr = '0;
  int base_rx, base_done, rd0, wr0;

  assign bus_rdata = mem[bus_addr[7:0]];

  always @(negedge clk) begin
    if (ptv && (!tx_valid || tx_data != ptd)) tviol = tviol + 1;
    if (pbs && (!(bus_rd || bus_wr) || bus_addr != pba)) bviol = bviol + 1;
    txc = txc + 1;
    tx_ready = !stall || txc[0];
    if (bus_rd || bus_wr) begin
      bus_ready = (wc == delay);
      if (bus_ready) wc = 0; else wc = wc + 1;
    end else begin
      bus_ready = 1'b0;
      wc = 0;
    end
    if (bus_wr && bus_ready) begin
      nwr = nwr + 1;
      last_waddr = bus_addr;
      if (bus_addr[15:8] != 8'hEE) mem[bus_addr[7:0]] = bus_wdata;
    end
    if (bus_rd && bus_ready) begin
      nrd = nrd + 1;
      last_raddr = bus_addr;
    end
    if (tx_valid && tx_ready) begin
      rx[nrx % 1024] = tx_data;
      nrx = nrx + 1;
    end
    if (done) begin
      ndone = ndone + 1;
      done_nrx = nrx;
    end
    ptv = tx_valid && !tx_ready;
    ptd = tx_data;
    pbs = (bus_rd || bus_wr) && !bus_ready;
    pba = bus_addr;
  end

  task automatic chk(input string r, input int a, input int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, a, e);
    end
  endtask

  task automatic setp(input int i, input logic [7:0] v);
    frm_data[8*i +: 8] = v;
  endtask

  task automatic run(input logic [7:0] f, input logic [7:0] l);
    int t = 0;
    base_rx = nrx; base_done = ndone; rd0 = nrd; wr0 = nwr;
    @(negedge clk);
    frm_func = f; frm_len = l; frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    while (ndone == base_done && t < 5000) begin
      @(posedge clk);
      t++;
    end
    if (ndone == base_done) begin
      total++; bad++;
      $display("FAIL R12 no done act=0 exp=1");
    end
    @(negedge clk);
  endtask

  task automatic expect_reply(input string r, input logic [7:0] f);
    logic [7:0] s;
    s = f + 8'(elen);
    chk({r, " R8 count"}, nrx - base_rx, elen + 3);
    chk({r, " R12 done timing"}, done_nrx - base_rx, elen + 3);
    chk({r, " R12 done once"}, ndone - base_done, 1);
    chk({r, " func"}, rx[base_rx % 1024], f);
    chk({r, " len"}, rx[(base_rx + 1) % 1024], elen);
    for (int i = 0; i < elen; i++) begin
      chk({r, " data"}, rx[(base_rx + 2 + i) % 1024], ex[i]);
      s = s + ex[i];
    end
    chk({r, " R8 checksum"}, rx[(base_rx + 2 + elen) % 1024], 8'(8'd0 - s));
  endtask

  task automatic rd_cmd(input logic [7:0] lo, input logic [7:0] hi, input int n);
    setp(0, 8'hA5); setp(1, lo); setp(2, hi); setp(3, 8'(n));
    run(8'hFE, 8'd4);
  endtask

  task automatic t_read;
    delay = 2; stall = 1;
    for (int i = 0; i < 5; i++) ex[i] = mem[8'h10 + i];
    elen = 5;
    rd_cmd(8'h10, 8'h03, 5);
    expect_reply("R3 read", 8'hFE);
    chk("R3 read count", nrd - rd0, 5);
    chk("R3 address order", last_raddr, 16'h0314);
  endtask

  task automatic t_read0;
    delay = 0; stall = 0; elen = 0;
    rd_cmd(8'h10, 8'h00, 0);
    expect_reply("R3 zero count", 8'hFE);
    chk("R3 zero no access", nrd - rd0, 0);
  endtask

  task automatic t_write_ok;
    delay = 1; stall = 0;
    setp(0, 8'h33); setp(1, 8'h40); setp(2, 8'h00);
    for (int i = 0; i < 4; i++) setp(3 + i, 8'hA1 + 8'(i));
    run(8'hFD, 8'd7);
    elen = 1; ex[0] = 8'h00;
    expect_reply("R4 write ok", 8'hFD);
    chk("R4 writes", nwr - wr0, 4);
    chk("R4 verifies", nrd - rd0, 4);
    for (int i = 0; i < 4; i++) ex[i] = 8'hA1 + 8'(i);
    elen = 4;
    rd_cmd(8'h40, 8'h00, 4);
    expect_reply("R4 readback", 8'hFE);
  endtask

  task automatic t_write_bad;
    delay = 0; stall = 1;
    setp(0, 8'h00); setp(1, 8'h02); setp(2, 8'hEE);
    for (int i = 0; i < 3; i++) setp(3 + i, ~mem[2 + i]);
    run(8'hFD, 8'd6);
    elen = 1; ex[0] = 8'h01;
    expect_reply("R4 write fail", 8'hFD);
    chk("R4 fail writes", nwr - wr0, 3);
    chk("R4 stop at first mismatch", nrd - rd0, 1);
  endtask

  task automatic t_write_empty;
    delay = 0; stall = 0; elen = 1; ex[0] = 8'h00;
    run(8'hFD, 8'd3);
    expect_reply("R4 len3", 8'hFD);
    chk("R4 len3 no access", (nrd - rd0) + (nwr - wr0), 0);
    run(8'hFD, 8'd1);
    expect_reply("R4 len1", 8'hFD);
    chk("R4 len1 no access", (nrd - rd0) + (nwr - wr0), 0);
  endtask

  task automatic t_set;
    delay = 1; stall = 1;
    ex[0] = mem[8'h20]; ex[1] = mem[8'h21]; ex[2] = mem[8'h30];
    setp(0, 8'h00); setp(1, 8'h20); setp(2, 8'h00); setp(3, 8'h11);
    setp(4, 8'h00); setp(5, 8'h21); setp(6, 8'h00); setp(7, 8'h22);
    setp(8, 8'h00); setp(9, 8'h30); setp(10, 8'h00); setp(11, 8'h33);
    elen = 3;
    run(8'hF9, 8'd12);
    expect_reply("R5 set", 8'hF9);
    ex[0] = 8'h11; ex[1] = 8'h22; elen = 2;
    rd_cmd(8'h20, 8'h00, 2);
    expect_reply("R5 set readback", 8'hFE);
    ex[0] = 8'h33; elen = 1;
    rd_cmd(8'h30, 8'h00, 1);
    expect_reply("R5 set readback2", 8'hFE);
  endtask

  task automatic t_set_abort;
    logic [7:0] keep;
    delay = 0; stall = 0;
    ex[0] = mem[8'h50]; keep = mem[8'h52];
    setp(0, 8'h00); setp(1, 8'h50); setp(2, 8'h00); setp(3, 8'h99);
    setp(4, 8'h00); setp(5, 8'h51); setp(6, 8'hEE); setp(7, mem[8'h51] ^ 8'h01);
    setp(8, 8'h00); setp(9, 8'h52); setp(10, 8'h00); setp(11, ~keep);
    elen = 1;
    run(8'hF9, 8'd12);
    expect_reply("R5 abort", 8'hF9);
    chk("R5 abort writes", nwr - wr0, 2);
    ex[0] = keep; elen = 1;
    rd_cmd(8'h52, 8'h00, 1);
    expect_reply("R5 later group untouched", 8'hFE);
  endtask

  task automatic t_port_out;
    delay = 2; stall = 0;
    setp(0, 8'h60); setp(1, 8'h01); setp(2, 8'h3C);
    run(8'hF7, 8'd3);
    elen = 1; ex[0] = 8'h00;
    expect_reply("R6 port out", 8'hF7);
    chk("R6 no read", nrd - rd0, 0);
    chk("R6 one write", nwr - wr0, 1);
    chk("R6 address", last_waddr, 16'h0160);
    ex[0] = 8'h3C;
    rd_cmd(8'h60, 8'h00, 1);
    expect_reply("R6 written data", 8'hFE);
  endtask

  task automatic t_port_in;
    delay = 1; stall = 1;
    setp(0, 8'h61); setp(1, 8'h02);
    elen = 1; ex[0] = mem[8'h61];
    run(8'hF8, 8'd2);
    expect_reply("R7 port in", 8'hF8);
    chk("R7 one read", nrd - rd0, 1);
    chk("R7 address", last_raddr, 16'h0261);
  endtask

  task automatic t_status;
    delay = 0; stall = 1; elen = DLEN;
    for (int i = 0; i < DLEN; i++) ex[i] = DVAL[8*i +: 8];
    run(8'hFF, 8'd0);
    expect_reply("R9 descriptor", 8'hFF);
  endtask

  task automatic t_unknown;
    delay = 0; stall = 0; elen = 1; ex[0] = 8'h01;
    run(8'hFC, 8'd0);
    expect_reply("R2 unknown FC", 8'hF0);
    chk("R2 no access", (nrd - rd0) + (nwr - wr0), 0);
    run(8'h12, 8'd2);
    expect_reply("R2 unknown 12", 8'hF0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 bus_rd", bus_rd, 0);
    chk("R1 bus_wr", bus_wr, 0);
    chk("R1 done", done, 0);
    t_read;
    t_read0;
    t_write_ok;
    t_write_bad;
    t_write_empty;
    t_set;
    t_set_abort;
    t_port_out;
    t_port_in;
    t_status;
    t_unknown;
    chk("R10 bus hold", bviol, 0);
    chk("R11 tx hold", tviol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule